// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block is the digital scheduler for a multi-channel successive-approximation converter. Software loads a mode word and a table of eight per-slot channel numbers. A trigger is either the software start strobe or one of two external events, chosen by a select field. A trigger starts a sample-and-hold window of programmable length, then a conversion-start pulse to the converter. When the converter reports done, the 12-bit result is packed with the channel number into a data word, an end-of-conversion flag is set, and either an interrupt pulse or a DMA request follows.

The controller is a four-state machine. IDLE waits for a trigger. SAMPLE holds the sample window. CONV waits for the converter. HALT is the stop at the end of a sequence when auto-restart is off. The transitions are these. IDLE goes to SAMPLE on an accepted trigger. HALT goes to SAMPLE only on a software start. SAMPLE goes to CONV when the window ends, and this transition fires the conversion start. When a conversion completes, CONV goes to one of three states. It goes to SAMPLE in burst mode when more work follows. It goes to IDLE in single mode, or after a wrapped sequence in single mode. It goes to HALT at the end of a sequence without auto-restart. Clearing the enable bit sends every state to IDLE.

In single mode each trigger performs one slot of the sequence. In burst mode one trigger runs the remaining slots back to back.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset every output is zero. The mode word reads as all zero, so the controller is disabled.
- R2: The mode word is loaded when `mode_we` is high. Its bit 0 is enable, bit 1 is auto-restart, bits 3:2 are the conversion mode, bits 5:4 are the trigger select, bits 9:6 are the sample field N, bits 12:10 are the sequence count, bit 13 is DMA enable and bit 14 is the low-tag option. Once a trigger is accepted, `sh_window` is high for exactly N+2 cycles. `conv_start` is a one-cycle pulse in the cycle right after the window.
- R3: A sequence-count value C gives C+1 conversions per sequence, so 000 gives 1 and 111 gives 8. `conv_chan` always shows the channel-table entry of the current slot, and slot 0 comes first.
- R4: In single mode (mode 00), each accepted trigger performs exactly one conversion and advances the slot index.
- R5: In burst mode (mode 01), one accepted trigger runs every remaining slot of the sequence without further triggers.
- R6: In modes 10 and 11 no trigger starts a conversion.
- R7: With auto-restart set, the slot index wraps to 0 after the last slot. Burst mode then continues at once, and single mode waits for the next trigger. With auto-restart clear, the controller halts after the last slot. In the halted state only `sw_start` restarts it, and external events are ignored.
- R8: `sw_start` is always a trigger. Trigger select 01 adds `timer_evt`, select 10 adds `pwm_evt`, and select 00 and 11 add no external event.
- R9: Triggers that arrive while a window or a conversion is in progress are ignored.
- R10: With DMA enabled, each completed conversion raises `dma_req`, which stays high until `dma_done`. `irq` pulses one cycle after `dma_done` is seen while the request is high, and never on the conversion itself.
- R11: With DMA disabled, `irq` is a one-cycle pulse in the cycle after the converter's done is accepted.
- R12: By default the data word holds the result in bits 11:0 and the channel in bits 19:16. With the low-tag option set, it holds the channel in bits 3:0 and the result in bits 15:4. All other bits are zero.
- R13: `eoc_flag` sets when a result is stored and clears on `data_rd`. If both happen in the same cycle, the set wins.
- R14: While enable is clear, the controller sits in IDLE with slot index 0, no window, no conversion start and no DMA request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Load strobe for the mode word |
| mode_wdata | input | 15 | Mode word value |
| chsel_we | input | 1 | Channel-table write strobe |
| chsel_idx | input | 3 | Channel-table slot to write |
| chsel_data | input | 4 | Channel number for that slot |
| sw_start | input | 1 | Software start strobe |
| timer_evt | input | 1 | Timer event trigger |
| pwm_evt | input | 1 | PWM event trigger |
| sh_window | output | 1 | Sample-and-hold window |
| conv_start | output | 1 | Conversion start pulse |
| conv_chan | output | 4 | Channel of the current slot |
| conv_done | input | 1 | Converter finished |
| conv_result | input | 12 | Converter result |
| data_word | output | 32 | Packed result and channel |
| eoc_flag | output | 1 | End-of-conversion flag |
| data_rd | input | 1 | Data-word read strobe |
| dma_req | output | 1 | DMA request |
| dma_done | input | 1 | DMA completion |
| irq | output | 1 | Interrupt pulse |

## Verification
The main function is exercised with several kinds of stimulus. Single-mode software strobes count one conversion per trigger. Burst triggers over sequence lengths 1, 3, 4 and 8 tell a whole-sequence run apart from a single step. Triggers on the unselected source, on select 11, in the reserved modes and while halted show which inputs are filtered out. A second trigger inside a long window shows that triggers are ignored while busy. DMA runs with the acknowledge withheld and then granted, which tells a deferred interrupt from an immediate one. Both tag placements are checked against a model that is compared on every cycle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int SAMP_W = 4;
    localparam int SEQ_W  = 3;
    localparam int NSLOT  = 1 << SEQ_W;
    localparam int MODE_W = 15;

    localparam logic [1:0] MD_SINGLE = 2'b00;
    localparam logic [1:0] MD_BURST  = 2'b01;

    localparam logic [1:0] TS_SOFT  = 2'b00;
    localparam logic [1:0] TS_TIMER = 2'b01;
    localparam logic [1:0] TS_PWM   = 2'b10;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SAMPLE,
        ST_CONV,
        ST_HALT
    } seq_state_t;

    typedef struct packed {
        logic              tag_low;
        logic              dma_en;
        logic [SEQ_W-1:0]  seq_cnt;
        logic [SAMP_W-1:0] samp;
        logic [1:0]        trig_sel;
        logic [1:0]        conv_mode;
        logic              auto_rst;
        logic              enable;
    } mode_t;

endpackage

// File: rtl/adc_seq_trig.sv
module adc_seq_trig
    import adc_seq_pkg::*;
(
    input  logic [1:0] trig_sel,
    input  logic       sw_start,
    input  logic       timer_evt,
    input  logic       pwm_evt,
    output logic       any_trig
);

    logic ext_hit;

    always_comb begin
        unique case (trig_sel)
            TS_TIMER: ext_hit = timer_evt;
            TS_PWM:   ext_hit = pwm_evt;
            TS_SOFT:  ext_hit = 1'b0;
            default:  ext_hit = 1'b0;
        endcase
        any_trig = sw_start | ext_hit;
    end

endmodule

// File: rtl/adc_seq_chtab.sv
module adc_seq_chtab #(
    parameter int SLOTS = 8,
    parameter int CH_W  = 4,
    localparam int IW   = $clog2(SLOTS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [IW-1:0]   widx,
    input  logic [CH_W-1:0] wdata,
    input  logic [IW-1:0]   ridx,
    output logic [CH_W-1:0] rchan
);

    logic [CH_W-1:0] entry_q [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                entry_q[g] <= '0;
            end else if (we && (widx == IW'(g))) begin
                entry_q[g] <= wdata;
            end
        end
    end

    assign rchan = entry_q[ridx];

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int SW   = SAMP_W,
    parameter int QW   = SEQ_W,
    localparam int CNT_W = SW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          auto_rst,
    input  logic [1:0]    conv_mode,
    input  logic [SW-1:0] samp,
    input  logic [QW-1:0] seq_cnt,
    input  logic          dma_en,
    input  logic          any_trig,
    input  logic          sw_start,
    input  logic          conv_done,
    input  logic          dma_done,
    output logic          sh_window,
    output logic          conv_start,
    output logic [QW-1:0] slot_idx,
    output logic          done_acc,
    output logic          dma_req,
    output logic          irq
);

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [QW-1:0]    idx_q, idx_d;
    logic             start_q, start_d;
    logic             dreq_q, irq_q;
    logic             accept;
    logic             mode_ok, burst, last_slot, win_end;

    assign mode_ok   = (conv_mode == MD_SINGLE) || (conv_mode == MD_BURST);
    assign burst     = (conv_mode == MD_BURST);
    assign last_slot = (idx_q == seq_cnt);
    assign win_end   = (cnt_q == (CNT_W'(samp) + CNT_W'(1)));

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        idx_d   = idx_q;
        start_d = 1'b0;
        accept  = 1'b0;
        if (!enable) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
            idx_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (any_trig && mode_ok) begin
                        state_d = ST_SAMPLE;
                        cnt_d   = '0;
                    end
                end
                ST_HALT: begin
                    if (sw_start && mode_ok) begin
                        state_d = ST_SAMPLE;
                        cnt_d   = '0;
                    end
                end
                ST_SAMPLE: begin
                    if (win_end) begin
                        state_d = ST_CONV;
                        start_d = 1'b1;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                ST_CONV: begin
                    if (conv_done) begin
                        accept = 1'b1;
                        cnt_d  = '0;
                        if (last_slot) begin
                            idx_d = '0;
                            if (!auto_rst)  state_d = ST_HALT;
                            else if (burst) state_d = ST_SAMPLE;
                            else            state_d = ST_IDLE;
                        end else begin
                            idx_d   = idx_q + QW'(1);
                            state_d = burst ? ST_SAMPLE : ST_IDLE;
                        end
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            start_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            idx_q   <= idx_d;
            start_q <= start_d;
        end
    end

    // request and interrupt register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dreq_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (!enable) begin
                dreq_q <= 1'b0;
            end else begin
                if (dreq_q && dma_done) irq_q <= 1'b1;
                if (accept && !dma_en)  irq_q <= 1'b1;
                if (accept && dma_en)
                    dreq_q <= 1'b1;
                else if (dreq_q && dma_done)
                    dreq_q <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        sh_window  = (state_q == ST_SAMPLE);
        conv_start = start_q;
        slot_idx   = idx_q;
        done_acc   = accept;
        dma_req    = dreq_q;
        irq        = irq_q;
    end

endmodule

// File: rtl/adc_seq_pack.sv
module adc_seq_pack #(
    parameter int CH_W   = 4,
    parameter int RES_W  = 12,
    parameter int DATA_W = 32,
    parameter int HI_POS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              tag_low,
    input  logic [CH_W-1:0]   chan,
    input  logic [RES_W-1:0]  result,
    input  logic              data_rd,
    output logic [DATA_W-1:0] data_word,
    output logic              eoc_flag
);

    logic [DATA_W-1:0] word_d, word_q;
    logic              eoc_q;

    always_comb begin
        word_d = '0;
        if (tag_low) begin
            word_d[CH_W-1:0]          = chan;
            word_d[CH_W+RES_W-1:CH_W] = result;
        end else begin
            word_d[RES_W-1:0]             = result;
            word_d[HI_POS+CH_W-1:HI_POS]  = chan;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            eoc_q  <= 1'b0;
        end else begin
            if (capture) begin
                word_q <= word_d;
                eoc_q  <= 1'b1;
            end else if (data_rd) begin
                eoc_q <= 1'b0;
            end
        end
    end

    assign data_word = word_q;
    assign eoc_flag  = eoc_q;

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int CH_W   = 4,
    parameter int RES_W  = 12,
    parameter int DATA_W = 32,
    parameter int HI_POS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              chsel_we,
    input  logic [SEQ_W-1:0]  chsel_idx,
    input  logic [CH_W-1:0]   chsel_data,
    input  logic              sw_start,
    input  logic              timer_evt,
    input  logic              pwm_evt,
    output logic              sh_window,
    output logic              conv_start,
    output logic [CH_W-1:0]   conv_chan,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_result,
    output logic [DATA_W-1:0] data_word,
    output logic              eoc_flag,
    input  logic              data_rd,
    output logic              dma_req,
    input  logic              dma_done,
    output logic              irq
);

    mode_t             mode_q;
    logic              any_trig;
    logic              done_acc;
    logic [SEQ_W-1:0]  slot_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (mode_we) begin
            mode_q <= mode_t'(mode_wdata);
        end
    end

    adc_seq_trig u_trig (
        .trig_sel  (mode_q.trig_sel),
        .sw_start  (sw_start),
        .timer_evt (timer_evt),
        .pwm_evt   (pwm_evt),
        .any_trig  (any_trig)
    );

    adc_seq_chtab #(
        .SLOTS (NSLOT),
        .CH_W  (CH_W)
    ) u_chtab (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (chsel_we),
        .widx  (chsel_idx),
        .wdata (chsel_data),
        .ridx  (slot_idx),
        .rchan (conv_chan)
    );

    adc_seq_fsm #(
        .SW (SAMP_W),
        .QW (SEQ_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (mode_q.enable),
        .auto_rst   (mode_q.auto_rst),
        .conv_mode  (mode_q.conv_mode),
        .samp       (mode_q.samp),
        .seq_cnt    (mode_q.seq_cnt),
        .dma_en     (mode_q.dma_en),
        .any_trig   (any_trig),
        .sw_start   (sw_start),
        .conv_done  (conv_done),
        .dma_done   (dma_done),
        .sh_window  (sh_window),
        .conv_start (conv_start),
        .slot_idx   (slot_idx),
        .done_acc   (done_acc),
        .dma_req    (dma_req),
        .irq        (irq)
    );

    adc_seq_pack #(
        .CH_W   (CH_W),
        .RES_W  (RES_W),
        .DATA_W (DATA_W),
        .HI_POS (HI_POS)
    ) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (done_acc),
        .tag_low   (mode_q.tag_low),
        .chan      (conv_chan),
        .result    (conv_result),
        .data_rd   (data_rd),
        .data_word (data_word),
        .eoc_flag  (eoc_flag)
    );

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk
    import adc_seq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sh_window,
    input logic              conv_start,
    input logic              dma_req,
    input logic              dma_done,
    input logic              irq,
    input logic              eoc_flag,
    input logic              done_acc,
    input logic [MODE_W-1:0] mode_bits
);

    // R2: the start pulse follows directly on a window cycle
    assert_start_after_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $past(sh_window));

    // R2: a window that closes while enabled lasted at least two cycles
    assert_window_min_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sh_window) && $past(mode_bits[0])) |-> $past(sh_window, 2));

    // R2: the start is a single-cycle pulse
    assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R10: with DMA enabled an interrupt needs a DMA completion
    assert_dma_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(mode_bits[13])) |-> $past(dma_done));

    // R14: a disabled controller drives no window, start or request
    assert_disable_quiet_R14: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!mode_bits[0]) |-> (!dma_req && !sh_window && !conv_start));

    // R13: a stored result always leaves the flag set
    assert_eoc_set_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $past(done_acc) |-> eoc_flag);

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sh_window  (sh_window),
    .conv_start (conv_start),
    .dma_req    (dma_req),
    .dma_done   (dma_done),
    .irq        (irq),
    .eoc_flag   (eoc_flag),
    .done_acc   (done_acc),
    .mode_bits  (mode_q)
);

// File: tb/adc_seq_ctrl_bench.sv
`timescale 1ns/1ps
module adc_seq_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_we = 1'b0;
    logic [14:0] mode_wdata = '0;
    logic        chsel_we = 1'b0;
    logic [2:0]  chsel_idx = '0;
    logic [3:0]  chsel_data = '0;
    logic        sw_start = 1'b0, timer_evt = 1'b0, pwm_evt = 1'b0;
    logic        sh_window, conv_start;
    logic [3:0]  conv_chan;
    logic        conv_done = 1'b0;
    logic [11:0] conv_result = '0;
    logic [31:0] data_word;
    logic        eoc_flag;
    logic        data_rd = 1'b0;
    logic        dma_req;
    logic        dma_done = 1'b0;
    logic        irq;

    always #10 clk = ~clk;

    adc_seq_ctrl u_adc_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .chsel_we(chsel_we), .chsel_idx(chsel_idx), .chsel_data(chsel_data),
        .sw_start(sw_start), .timer_evt(timer_evt), .pwm_evt(pwm_evt),
        .sh_window(sh_window), .conv_start(conv_start), .conv_chan(conv_chan),
        .conv_done(conv_done), .conv_result(conv_result), .data_word(data_word),
        .eoc_flag(eoc_flag), .data_rd(data_rd), .dma_req(dma_req),
        .dma_done(dma_done), .irq(irq)
    );

    int total = 0;
    int bad = 0;
    int nconv = 0;
    int nirq = 0;
    bit auto_dma = 1'b1;
    int clat = 0, dlat = 0;
    int seed = 17;
    logic [3:0] pend_ch = '0;
    logic [3:0] btab [8];

    // reference model state
    int          m_st = 0;
    int          m_cnt = 0, m_idx = 0;
    bit          m_cs = 0, m_dreq = 0, m_irq = 0, m_eoc = 0;
    logic [31:0] m_data = '0;
    logic [14:0] m_mode = '0;
    logic [3:0]  m_tab [8];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [14:0] mk(input bit en, input bit ar, input int md, input int ts,
                                       input int sp, input int sq, input bit dm, input bit tg);
        return {tg, dm, 3'(sq), 4'(sp), 2'(ts), 2'(md), ar, en};
    endfunction

    // behavioural model, updated on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_idx = 0; m_cs = 0; m_dreq = 0; m_irq = 0;
            m_eoc = 0; m_data = '0; m_mode = '0;
            for (int i = 0; i < 8; i++) m_tab[i] = '0;
        end else begin
            bit en, ar, dm, tg, trig, ok, acc, ni;
            int md, ts, sp, sq;
            logic [3:0] ch;
            en = m_mode[0]; ar = m_mode[1]; md = int'(m_mode[3:2]); ts = int'(m_mode[5:4]);
            sp = int'(m_mode[9:6]); sq = int'(m_mode[12:10]); dm = m_mode[13]; tg = m_mode[14];
            trig = sw_start || (ts == 1 && timer_evt) || (ts == 2 && pwm_evt);
            ok = (md < 2);
            acc = 0; ni = 0; m_cs = 0;
            ch = m_tab[m_idx];
            if (!en) begin
                m_st = 0; m_idx = 0; m_cnt = 0;
            end else begin
                case (m_st)
                    0: if (trig && ok) begin m_st = 1; m_cnt = 0; end
                    3: if (sw_start && ok) begin m_st = 1; m_cnt = 0; end
                    1: if (m_cnt == sp + 1) begin m_st = 2; m_cs = 1; end else m_cnt++;
                    default: if (conv_done) begin
                        acc = 1; m_cnt = 0;
                        if (m_idx == sq) begin
                            m_idx = 0;
                            m_st = !ar ? 3 : (md == 1 ? 1 : 0);
                        end else begin
                            m_idx++;
                            m_st = (md == 1) ? 1 : 0;
                        end
                    end
                endcase
            end
            if (!en) m_dreq = 0;
            else begin
                if (m_dreq && dma_done) begin ni = 1; m_dreq = 0; end
                if (acc && dm) m_dreq = 1;
                if (acc && !dm) ni = 1;
            end
            m_irq = ni;
            if (acc) begin
                m_data = tg ? ((32'(conv_result) << 4) | 32'(ch))
                            : ((32'(ch) << 16) | 32'(conv_result));
                m_eoc = 1;
            end else if (data_rd) m_eoc = 0;
            if (mode_we) m_mode = mode_wdata;
            if (chsel_we) m_tab[chsel_idx] = chsel_data;
        end
    end

    // per-cycle comparison, event counting and converter/DMA stubs
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 sh_window", 32'(sh_window), 32'(m_st == 1));
            chk("R2 conv_start", 32'(conv_start), 32'(m_cs));
            chk("R3 conv_chan", 32'(conv_chan), 32'(m_tab[m_idx]));
            chk("R10 dma_req", 32'(dma_req), 32'(m_dreq));
            chk("R11 irq", 32'(irq), 32'(m_irq));
            chk("R12 data_word", data_word, m_data);
            chk("R13 eoc_flag", 32'(eoc_flag), 32'(m_eoc));
            if (conv_start) nconv++;
            if (irq) nirq++;
        end
        if (conv_done) conv_done = 1'b0;
        if (clat > 0) begin
            clat--;
            if (clat == 0) begin
                conv_done = 1'b1;
                conv_result = {pend_ch, 8'h00} ^ 12'(seed);
                seed = seed + 37;
            end
        end
        if (conv_start) begin clat = 3; pend_ch = conv_chan; end
        if (dma_done) dma_done = 1'b0;
        if (dlat > 0) begin
            dlat--;
            if (dlat == 0) dma_done = 1'b1;
        end else if (auto_dma && dma_req && !dma_done) dlat = 2;
    end

    task automatic wmode(input logic [14:0] v);
        @(negedge clk); mode_we = 1'b1; mode_wdata = v;
        @(negedge clk); mode_we = 1'b0;
    endtask

    task automatic pulse_sw();
        @(negedge clk); sw_start = 1'b1; @(negedge clk); sw_start = 1'b0;
    endtask
    task automatic pulse_tm();
        @(negedge clk); timer_evt = 1'b1; @(negedge clk); timer_evt = 1'b0;
    endtask
    task automatic pulse_pw();
        @(negedge clk); pwm_evt = 1'b1; @(negedge clk); pwm_evt = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle(1);
        chk("R1 reset sh_window", 32'(sh_window), 0);
        chk("R1 reset data_word", data_word, 0);
        chk("R1 reset flags", {28'd0, eoc_flag, dma_req, irq, conv_start}, 0);

        for (int i = 0; i < 8; i++) begin
            btab[i] = 4'((i * 5 + 3) % 16);
            @(negedge clk); chsel_we = 1'b1; chsel_idx = 3'(i); chsel_data = btab[i];
        end
        @(negedge clk); chsel_we = 1'b0;

        // R14: triggers while disabled
        base = nconv; pulse_sw(); settle(20);
        chk("R14 disabled trigger", 32'(nconv - base), 0);

        // R4 single mode, three slots, no restart
        wmode(mk(1, 0, 0, 0, 0, 2, 0, 0));
        chk("R3 first slot channel", 32'(conv_chan), 32'(btab[0]));
        base = nconv; pulse_sw(); settle(20);
        chk("R4 one conversion per trigger", 32'(nconv - base), 1);
        chk("R3 slot advanced", 32'(conv_chan), 32'(btab[1]));
        base = nirq;
        pulse_sw(); settle(20); pulse_sw(); settle(20);
        chk("R11 irq per conversion", 32'(nirq - base), 2);
        chk("R13 eoc set", 32'(eoc_flag), 1);
        @(negedge clk); data_rd = 1'b1; @(negedge clk); data_rd = 1'b0; settle(1);
        chk("R13 eoc cleared by read", 32'(eoc_flag), 0);
        // R7 halted: external event ignored, software restarts
        wmode(mk(1, 0, 0, 1, 0, 2, 0, 0));
        base = nconv; pulse_tm(); settle(20);
        chk("R7 halt ignores timer", 32'(nconv - base), 0);
        pulse_sw(); settle(20);
        chk("R7 sw restarts from halt", 32'(nconv - base), 1);

        // R8 trigger select
        wmode(mk(0, 1, 0, 2, 1, 0, 0, 1));
        wmode(mk(1, 1, 0, 2, 1, 0, 0, 1));
        base = nconv; pulse_tm(); settle(20);
        chk("R8 unselected timer ignored", 32'(nconv - base), 0);
        pulse_pw(); settle(20);
        chk("R8 pwm selected", 32'(nconv - base), 1);
        pulse_sw(); settle(20);
        chk("R8 sw always triggers", 32'(nconv - base), 2);
        wmode(mk(1, 1, 0, 3, 1, 0, 0, 0));
        base = nconv; pulse_tm(); pulse_pw(); settle(20);
        chk("R8 select 11 ignores events", 32'(nconv - base), 0);

        // R5 burst, four slots, plus a trigger during the window (R9)
        wmode(mk(0, 0, 1, 1, 5, 3, 0, 0));
        wmode(mk(1, 0, 1, 1, 5, 3, 0, 0));
        base = nconv; pulse_tm(); settle(2); pulse_tm(); settle(100);
        chk("R5 burst runs four", 32'(nconv - base), 4);
        chk("R9 busy trigger ignored", 32'(nconv - base), 4);
        // R3 sequence lengths 8 and 1
        wmode(mk(0, 0, 1, 0, 0, 7, 0, 0));
        wmode(mk(1, 0, 1, 0, 0, 7, 0, 0));
        base = nconv; pulse_sw(); settle(120);
        chk("R3 count 111 gives eight", 32'(nconv - base), 8);
        wmode(mk(0, 0, 1, 0, 0, 0, 0, 0));
        wmode(mk(1, 0, 1, 0, 0, 0, 0, 0));
        base = nconv; pulse_sw(); settle(30);
        chk("R3 count 000 gives one", 32'(nconv - base), 1);
        // R9 in single mode with long window
        wmode(mk(1, 1, 0, 0, 15, 7, 0, 0));
        base = nconv; pulse_sw(); settle(3); pulse_sw(); settle(60);
        chk("R9 second strobe ignored", 32'(nconv - base), 1);

        // R6 reserved modes
        wmode(mk(0, 1, 2, 0, 0, 0, 0, 0));
        wmode(mk(1, 1, 2, 0, 0, 0, 0, 0));
        base = nconv; pulse_sw(); settle(20);
        wmode(mk(1, 1, 3, 0, 0, 0, 0, 0));
        pulse_sw(); settle(20);
        chk("R6 reserved modes idle", 32'(nconv - base), 0);

        // R10 DMA, low tag
        wmode(mk(1, 1, 0, 0, 2, 1, 1, 1));
        base = nirq; pulse_sw(); settle(30); pulse_sw(); settle(30);
        chk("R10 irq after each dma done", 32'(nirq - base), 2);
        auto_dma = 1'b0;
        base = nirq; pulse_sw(); settle(30);
        chk("R10 request held", 32'(dma_req), 1);
        chk("R10 irq held off", 32'(nirq - base), 0);
        auto_dma = 1'b1; settle(10);
        chk("R10 irq on dma done", 32'(nirq - base), 1);

        // R7 auto-restart burst, then R14 disable
        auto_dma = 1'b0;
        wmode(mk(0, 1, 1, 2, 1, 2, 1, 0));
        wmode(mk(1, 1, 1, 2, 1, 2, 1, 0));
        base = nconv; pulse_pw(); settle(60);
        chk("R7 wrap keeps running", 32'(nconv - base > 3), 1);
        wmode(mk(0, 1, 1, 2, 1, 2, 1, 0));
        settle(2);
        chk("R14 window low", 32'(sh_window), 0);
        chk("R14 request dropped", 32'(dma_req), 0);
        base = nconv; settle(30);
        chk("R14 no conversions", 32'(nconv - base), 0);
        auto_dma = 1'b1;
        wmode(mk(1, 0, 0, 0, 0, 2, 0, 0));
        chk("R14 slot index reset", 32'(conv_chan), 32'(btab[0]));
        settle(5);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule